// File: doc/BRIEF.md
# Multiply Unit with Structural-Hazard Interlock

This block is a five-stage integer multiply unit together with the issue interlock that protects it. A decode stage presents a request with two operands and a destination tag. The unit either accepts the request in that cycle or raises an issue-stall. A stalled request is held, not dropped, and enters as soon as the unit can take it. Each stage adds one slice of the multiplier's partial product, so the full product comes out of the last stage five cycles after acceptance, together with its tag.

A parameter selects one of two variants of the same datapath. In the pipelined variant a new operation may enter on every cycle and the unit never stalls. In the single-occupancy variant only one operation may be anywhere in the five stages. A request that arrives while an operation is still in flight is stalled until the last stage has drained. Requests spaced far enough apart pass without stalls in either variant. Only clustered requests pay the penalty.

Top module: `mul_hazard_unit`

## Requirements
- R1: A request accepted in cycle k (req_valid high, issue_stall low) produces res_valid high in cycle k+5.
- R2: res_product is the unsigned full-width product of the accepted operands (2*DATA_W bits), including the all-ones and zero extremes.
- R3: In single-occupancy mode (MODE = MODE_NONPIPE), issue_stall is high exactly when req_valid is high and some operation has been accepted whose result has not yet been delivered, i.e. during cycles k+1 to k+5 after an acceptance in cycle k.
- R4: A stalled request is not lost. It is accepted in the first cycle the unit is free. In single-occupancy mode, N requests issued back to back therefore cost 5*(N-1) stall cycles, and the requester keeps operands and tag stable while stalled.
- R5: In pipelined mode (MODE = MODE_PIPE), issue_stall is never raised, and requests presented on consecutive cycles are accepted on consecutive cycles.
- R6: Requests spaced at least 6 cycles apart never stall, in either mode.
- R7: res_valid is high for exactly one cycle per accepted operation. Results leave in acceptance order, with the tag of their own request.
- R8: A synchronous reset clears every stage, drops issue_stall, and discards any operation in flight, so that operation never produces a result.
- R9: issue_stall is low whenever req_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Issue request from decode |
| req_a | input | DATA_W | Multiplicand |
| req_b | input | DATA_W | Multiplier |
| req_tag | input | TAG_W | Destination tag of the request |
| issue_stall | output | 1 | Structural-hazard stall back to decode |
| res_valid | output | 1 | Result available this cycle |
| res_tag | output | TAG_W | Tag of the delivered result |
| res_product | output | 2*DATA_W | Unsigned product |

## Verification
The assertions track how many operations are in flight, using a counter built from the ports. On every cycle they check that a stall needs a request, that the single-occupancy unit holds at most one operation and stalls exactly while it is occupied, that the pipelined unit never stalls, that a stalled request stays stable, and that the outputs are clear after reset. Product values, the five-cycle latency, tag ordering and the stall totals for clustered versus spread-out traffic can only be shown by the bench's scenarios. The bench runs both variants side by side against a behavioural model.

// File: rtl/mul_pkg.sv
package mul_pkg;

    typedef enum logic {
        MODE_NONPIPE = 1'b0,
        MODE_PIPE    = 1'b1
    } mul_mode_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/mul_issue_gate.sv
module mul_issue_gate
    import mul_pkg::*;
#(
    parameter mul_mode_e MODE  = MODE_NONPIPE,
    parameter int        DEPTH = 5
) (
    input  logic             req_valid,
    input  logic [DEPTH-1:0] occupied,
    output logic             stall,
    output logic             accept
);

    generate
        if (MODE == MODE_PIPE) begin : g_pipe
            // Every stage advances each cycle, so a new entry never collides.
            logic unused_occ;
            assign unused_occ = |occupied;
            assign stall      = 1'b0;
        end else begin : g_single
            // Any live stage blocks entry until the last stage drains.
            assign stall = req_valid & (|occupied);
        end
    endgenerate

    assign accept = req_valid & ~stall;

endmodule

// File: rtl/mul_slice_stage.sv
module mul_slice_stage #(
    parameter int DATA_W  = 16,
    parameter int TAG_W   = 4,
    parameter int SLICE_W = 4,
    parameter int BPAD_W  = 20,
    parameter int IDX     = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [TAG_W-1:0]      in_tag,
    input  logic [DATA_W-1:0]     in_a,
    input  logic [BPAD_W-1:0]     in_b,
    input  logic [2*DATA_W-1:0]   in_acc,
    output logic                  out_valid,
    output logic [TAG_W-1:0]      out_tag,
    output logic [DATA_W-1:0]     out_a,
    output logic [BPAD_W-1:0]     out_b,
    output logic [2*DATA_W-1:0]   out_acc
);

    localparam int PROD_W = 2 * DATA_W;
    localparam int SHIFT  = IDX * SLICE_W;

    typedef struct packed {
        logic               valid;
        logic [TAG_W-1:0]   tag;
        logic [DATA_W-1:0]  a;
        logic [BPAD_W-1:0]  b;
        logic [PROD_W-1:0]  acc;
    } stage_t;

    stage_t              st_d, st_q;
    logic [SLICE_W-1:0]  digit;
    logic [PROD_W-1:0]   partial;

    always_comb begin
        digit   = SLICE_W'(in_b >> SHIFT);
        partial = (PROD_W'(in_a) * PROD_W'(digit)) << SHIFT;
        st_d    = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.tag = in_tag;
            st_d.a   = in_a;
            st_d.b   = in_b;
            st_d.acc = in_acc + partial;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_tag   = st_q.tag;
    assign out_a     = st_q.a;
    assign out_b     = st_q.b;
    assign out_acc   = st_q.acc;

endmodule

// File: rtl/mul_tail_stage.sv
module mul_tail_stage #(
    parameter int DATA_W  = 16,
    parameter int TAG_W   = 4,
    parameter int SLICE_W = 4,
    parameter int BPAD_W  = 20,
    parameter int IDX     = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [TAG_W-1:0]      in_tag,
    input  logic [DATA_W-1:0]     in_a,
    input  logic [BPAD_W-1:0]     in_b,
    input  logic [2*DATA_W-1:0]   in_acc,
    output logic                  out_valid,
    output logic [TAG_W-1:0]      out_tag,
    output logic [2*DATA_W-1:0]   out_acc
);

    localparam int PROD_W = 2 * DATA_W;
    localparam int SHIFT  = IDX * SLICE_W;

    typedef struct packed {
        logic               valid;
        logic [TAG_W-1:0]   tag;
        logic [PROD_W-1:0]  acc;
    } tail_t;

    tail_t               tl_d, tl_q;
    logic [SLICE_W-1:0]  digit;
    logic [PROD_W-1:0]   partial;

    always_comb begin
        digit   = SLICE_W'(in_b >> SHIFT);
        partial = (PROD_W'(in_a) * PROD_W'(digit)) << SHIFT;
        tl_d    = tl_q;
        tl_d.valid = in_valid;
        if (in_valid) begin
            tl_d.tag = in_tag;
            tl_d.acc = in_acc + partial;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tl_q <= '0;
        end else begin
            tl_q <= tl_d;
        end
    end

    assign out_valid = tl_q.valid;
    assign out_tag   = tl_q.tag;
    assign out_acc   = tl_q.acc;

endmodule

// File: rtl/mul_hazard_unit.sv
module mul_hazard_unit
    import mul_pkg::*;
#(
    parameter int        DATA_W = 16,
    parameter int        TAG_W  = 4,
    parameter int        DEPTH  = 5,
    parameter mul_mode_e MODE   = MODE_NONPIPE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [DATA_W-1:0]   req_a,
    input  logic [DATA_W-1:0]   req_b,
    input  logic [TAG_W-1:0]    req_tag,
    output logic                issue_stall,
    output logic                res_valid,
    output logic [TAG_W-1:0]    res_tag,
    output logic [2*DATA_W-1:0] res_product
);

    localparam int SLICE_W = ceil_div(DATA_W, DEPTH);
    localparam int BPAD_W  = SLICE_W * DEPTH;
    localparam int PROD_W  = 2 * DATA_W;

    // Chain index i is the input side of stage i.
    logic                v_ch   [DEPTH];
    logic [TAG_W-1:0]    tag_ch [DEPTH];
    logic [DATA_W-1:0]   a_ch   [DEPTH];
    logic [BPAD_W-1:0]   b_ch   [DEPTH];
    logic [PROD_W-1:0]   acc_ch [DEPTH];
    logic [DEPTH-1:0]    occupied;
    logic                accept;

    mul_issue_gate #(
        .MODE  (MODE),
        .DEPTH (DEPTH)
    ) u_gate (
        .req_valid (req_valid),
        .occupied  (occupied),
        .stall     (issue_stall),
        .accept    (accept)
    );

    assign v_ch[0]   = accept;
    assign tag_ch[0] = req_tag;
    assign a_ch[0]   = req_a;
    assign b_ch[0]   = BPAD_W'(req_b);
    assign acc_ch[0] = '0;

    generate
        for (genvar s = 0; s < DEPTH - 1; s++) begin : g_stage
            mul_slice_stage #(
                .DATA_W  (DATA_W),
                .TAG_W   (TAG_W),
                .SLICE_W (SLICE_W),
                .BPAD_W  (BPAD_W),
                .IDX     (s)
            ) u_stage (
                .clk       (clk),
                .rst       (rst),
                .in_valid  (v_ch[s]),
                .in_tag    (tag_ch[s]),
                .in_a      (a_ch[s]),
                .in_b      (b_ch[s]),
                .in_acc    (acc_ch[s]),
                .out_valid (v_ch[s+1]),
                .out_tag   (tag_ch[s+1]),
                .out_a     (a_ch[s+1]),
                .out_b     (b_ch[s+1]),
                .out_acc   (acc_ch[s+1])
            );
            assign occupied[s] = v_ch[s+1];
        end
    endgenerate

    mul_tail_stage #(
        .DATA_W  (DATA_W),
        .TAG_W   (TAG_W),
        .SLICE_W (SLICE_W),
        .BPAD_W  (BPAD_W),
        .IDX     (DEPTH - 1)
    ) u_tail (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (v_ch[DEPTH-1]),
        .in_tag    (tag_ch[DEPTH-1]),
        .in_a      (a_ch[DEPTH-1]),
        .in_b      (b_ch[DEPTH-1]),
        .in_acc    (acc_ch[DEPTH-1]),
        .out_valid (res_valid),
        .out_tag   (res_tag),
        .out_acc   (res_product)
    );

    assign occupied[DEPTH-1] = res_valid;

endmodule

// File: rtl/mul_hazard_checker.sv
module mul_hazard_checker
    import mul_pkg::*;
#(
    parameter int        DATA_W = 16,
    parameter int        TAG_W  = 4,
    parameter int        DEPTH  = 5,
    parameter mul_mode_e MODE   = MODE_NONPIPE
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [DATA_W-1:0] req_a,
    input logic [DATA_W-1:0] req_b,
    input logic [TAG_W-1:0]  req_tag,
    input logic              issue_stall,
    input logic              res_valid
);

    logic [7:0] flight_q;
    logic       prev_rst_q;
    logic       taken;

    assign taken = req_valid & ~issue_stall;

    always_ff @(posedge clk) begin
        if (rst) begin
            flight_q <= '0;
        end else begin
            flight_q <= flight_q + 8'(taken) - 8'(res_valid);
        end
    end

    always_ff @(posedge clk) begin
        prev_rst_q <= rst;
    end

    // R8: first cycle after reset shows no result and no stall
    always_ff @(posedge clk) begin
        if (prev_rst_q === 1'b1 && !rst) begin
            p_reset_clear_r8: assert (!res_valid && !issue_stall)
                else $error("outputs not clear after reset");
        end
    end

    p_stall_needs_req_r9: assert property (@(posedge clk) disable iff (rst)
        issue_stall |-> req_valid);

    p_flight_bound_r1: assert property (@(posedge clk) disable iff (rst)
        flight_q <= 8'(DEPTH));

    p_result_has_owner_r7: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (flight_q != 8'd0));

    p_hold_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && issue_stall) |=> (req_valid && $stable(req_a)
                                        && $stable(req_b) && $stable(req_tag)));

    generate
        if (MODE == MODE_NONPIPE) begin : g_single
            p_single_flight_r3: assert property (@(posedge clk) disable iff (rst)
                flight_q <= 8'd1);
            p_stall_when_busy_r3: assert property (@(posedge clk) disable iff (rst)
                (req_valid && flight_q != 8'd0) |-> issue_stall);
            p_no_stall_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
                (flight_q == 8'd0) |-> !issue_stall);
            p_result_spacing_r7: assert property (@(posedge clk) disable iff (rst)
                res_valid |=> !res_valid);
        end else begin : g_pipe
            p_never_stall_r5: assert property (@(posedge clk) disable iff (rst)
                !issue_stall);
        end
    endgenerate

endmodule

bind mul_hazard_unit mul_hazard_checker #(
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W),
    .DEPTH  (DEPTH),
    .MODE   (MODE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_a       (req_a),
    .req_b       (req_b),
    .req_tag     (req_tag),
    .issue_stall (issue_stall),
    .res_valid   (res_valid)
);

// File: tb/mul_hazard_unit_test.sv
module mul_hazard_unit_test;
    import mul_pkg::*;

    localparam int DW    = 16;
    localparam int TW    = 4;
    localparam int DEPTH = 5;
    localparam int NOPS  = 14;
    localparam int LAST  = 130;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic             rst = 1'b1;
    logic             rq   [2];
    logic [DW-1:0]    ra   [2];
    logic [DW-1:0]    rb   [2];
    logic [TW-1:0]    rt   [2];
    logic             st   [2];
    logic             rv   [2];
    logic [TW-1:0]    rtag [2];
    logic [2*DW-1:0]  rp   [2];

    mul_hazard_unit #(.DATA_W(DW), .TAG_W(TW), .DEPTH(DEPTH), .MODE(MODE_NONPIPE)) uut (
        .clk(clk), .rst(rst), .req_valid(rq[0]), .req_a(ra[0]), .req_b(rb[0]),
        .req_tag(rt[0]), .issue_stall(st[0]), .res_valid(rv[0]),
        .res_tag(rtag[0]), .res_product(rp[0]));

    mul_hazard_unit #(.DATA_W(DW), .TAG_W(TW), .DEPTH(DEPTH), .MODE(MODE_PIPE)) uut_pipe (
        .clk(clk), .rst(rst), .req_valid(rq[1]), .req_a(ra[1]), .req_b(rb[1]),
        .req_tag(rt[1]), .issue_stall(st[1]), .res_valid(rv[1]),
        .res_tag(rtag[1]), .res_product(rp[1]));

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    int              op_rel [NOPS];
    logic [DW-1:0]   op_a   [NOPS];
    logic [DW-1:0]   op_b   [NOPS];

    int              acc_cyc  [2][NOPS];
    logic [TW-1:0]   acc_tag  [2][NOPS];
    logic [2*DW-1:0] acc_prod [2][NOPS];
    int n_acc [2];
    int head  [2];
    int last_acc [2];
    int nxt [2];
    bit pres [2];
    int stall_cnt [2];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic add_op(input int i, input int rel, input logic [DW-1:0] a, input logic [DW-1:0] b);
        op_rel[i] = rel;
        op_a[i]   = a;
        op_b[i]   = b;
    endtask

    task automatic step();
        bit exp_st;
        bit exp_rv;
        @(negedge clk);
        cyc++;
        rst = (cyc <= 3) || (cyc == 112);
        for (int l = 0; l < 2; l++) begin
            if (!pres[l] && nxt[l] < NOPS && op_rel[nxt[l]] <= cyc && !rst) pres[l] = 1'b1;
            rq[l] = pres[l];
            if (pres[l]) begin
                ra[l] = op_a[nxt[l]];
                rb[l] = op_b[nxt[l]];
                rt[l] = TW'(nxt[l]);
            end
        end
        #1;
        for (int l = 0; l < 2; l++) begin
            exp_st = pres[l] && (l == 0) && (cyc <= last_acc[l] + DEPTH);
            chk(st[l] === exp_st, !pres[l] ? "R9" : (l == 1 ? "R5" : "R3"),
                "issue_stall", longint'(st[l]), longint'(exp_st));
            if (st[l] === 1'b1 && pres[l]) stall_cnt[l]++;
            exp_rv = (head[l] < n_acc[l]) && (acc_cyc[l][head[l]] + DEPTH == cyc);
            chk(rv[l] === exp_rv, "R1", "res_valid", longint'(rv[l]), longint'(exp_rv));
            if (exp_rv) begin
                chk(rtag[l] === acc_tag[l][head[l]], "R7", "res_tag",
                    longint'(rtag[l]), longint'(acc_tag[l][head[l]]));
                chk(rp[l] === acc_prod[l][head[l]], "R2", "res_product",
                    longint'(rp[l]), longint'(acc_prod[l][head[l]]));
                head[l]++;
            end
            if (rst) begin
                head[l] = n_acc[l];
                last_acc[l] = -100;
            end else if (pres[l] && !exp_st) begin
                acc_cyc[l][n_acc[l]]  = cyc;
                acc_tag[l][n_acc[l]]  = TW'(nxt[l]);
                acc_prod[l][n_acc[l]] = (2*DW)'(op_a[nxt[l]]) * (2*DW)'(op_b[nxt[l]]);
                n_acc[l]++;
                last_acc[l] = cyc;
                nxt[l]++;
                pres[l] = 1'b0;
            end
        end
    endtask

    initial begin
        // clustered burst
        add_op(0, 10, 16'd3, 16'd5);
        add_op(1, 10, 16'hFFFF, 16'd2);
        add_op(2, 10, 16'd1234, 16'd567);
        add_op(3, 10, 16'd0, 16'd999);
        // spread-out arrivals, 8 cycles apart
        add_op(4, 40, 16'd77, 16'd88);
        add_op(5, 48, 16'h8000, 16'h8000);
        add_op(6, 56, 16'd255, 16'd257);
        add_op(7, 64, 16'd4096, 16'd15);
        // clustered extremes
        add_op(8, 76, 16'hFFFF, 16'hFFFF);
        add_op(9, 76, 16'd0, 16'd0);
        add_op(10, 76, 16'd1, 16'hFFFF);
        add_op(11, 76, 16'hFFFF, 16'd1);
        // flushed by reset, then one after reset
        add_op(12, 110, 16'd9, 16'd9);
        add_op(13, 113, 16'd321, 16'd123);
        for (int l = 0; l < 2; l++) begin
            rq[l] = 1'b0; ra[l] = '0; rb[l] = '0; rt[l] = '0;
            n_acc[l] = 0; head[l] = 0; last_acc[l] = -100;
            nxt[l] = 0; pres[l] = 1'b0; stall_cnt[l] = 0;
        end
        while (cyc < LAST) begin
            step();
            if (cyc == 2) begin
                chk(st[0] === 1'b0 && rv[0] === 1'b0, "R8", "reset state single", longint'(rv[0]), 0);
                chk(st[1] === 1'b0 && rv[1] === 1'b0, "R8", "reset state pipe", longint'(rv[1]), 0);
            end
            if (cyc == 38) begin
                chk(stall_cnt[0] == 15, "R4", "cluster stalls single", stall_cnt[0], 15);
                chk(stall_cnt[1] == 0, "R5", "cluster stalls pipe", stall_cnt[1], 0);
            end
            if (cyc == 70) begin
                chk(stall_cnt[0] == 15, "R6", "spread stalls single", stall_cnt[0], 15);
                chk(stall_cnt[1] == 0, "R6", "spread stalls pipe", stall_cnt[1], 0);
            end
            if (cyc == 105) begin
                chk(stall_cnt[0] == 30, "R4", "extreme cluster stalls", stall_cnt[0], 30);
                chk(head[0] == 12 && head[1] == 12, "R7", "results delivered", head[0], 12);
            end
        end
        chk(stall_cnt[0] == 30, "R8", "no stall after reset", stall_cnt[0], 30);
        chk(n_acc[0] == NOPS && n_acc[1] == NOPS, "R4", "all requests accepted", n_acc[0], NOPS);
        chk(head[0] == n_acc[0] && head[1] == n_acc[1], "R7", "pipeline drained", head[0], n_acc[0]);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired at cycle %0d actual=hung expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule